// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO Slice

This block is one storage slice of a deep first-in first-out buffer built by chaining several identical slices in a ring. All slices share the write clock, the read clock, the write and read enables, the input data word and the output data bus. Two ownership tokens travel around the ring. The write token says which slice accepts the next word. The read token says which slice supplies the next word and drives the shared output bus. A slice passes a token on when it touches its last local storage location, so the chain behaves as one large buffer in which words leave in the order they arrived.

Each slice keeps its own write and read pointers, each with a wrap bit. The pointers cross between the two clock domains as Gray codes through a parameterised synchroniser. The local active-low empty and full flags are combined outside the block by the system. Exactly one slice carries the strap that marks it as the lead: it owns both tokens after reset.

Top module: `cascade_slice`

## Requirements
- R1: During and after reset, the slice with `lead_n` low holds both tokens and the slice with `lead_n` high holds neither. `empty_n` is 0, `full_n` is 1, `dout` is 0, and `wx_out` and `rx_out` are 0.
- R2: A write is stored only when the slice owns the write token, meaning it holds it or `wx_in` is high at that `wclk` edge. A slice without the token ignores `wr_en`.
- R3: Storing into local location DEPTH-1 raises `wx_out` for exactly one `wclk` cycle and releases the write token.
- R4: When `wx_in` is high at a `wclk` edge, the slice accepts a write at that same edge and holds the write token afterwards, so no cycle is lost at a handoff.
- R5: Reading local location DEPTH-1 raises `rx_out` for exactly one `rclk` cycle and releases the read token.
- R6: When `rx_in` is high at an `rclk` edge, the slice performs a read at that same edge and holds the read token afterwards.
- R7: A read happens only when the slice owns the read token and is not empty. It loads the oldest local word into `dout` one `rclk` edge later. `dout` holds its value when no read takes place.
- R8: `dout_drive` is high only when `out_en` is 1 and the slice holds the read token or is pulsing `rx_out`. In a ring, at most one slice drives at any time.
- R9: `full_n` is 0 while DEPTH words sit unread in the slice, and writes are then ignored. It returns to 1 SYNC_STAGES `wclk` edges after a read frees a location.
- R10: `empty_n` is updated only by `rclk`. It goes to 1 SYNC_STAGES `rclk` edges after the first unread word is stored, and to 0 right after the last local word is read.
- R11: Across the ring, words come out in the order they were written, also across token handoffs and ring wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, shared by the ring |
| rclk | input | 1 | Read clock, shared by the ring |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_n | input | 1 | Strap; low marks the slice that starts with both tokens |
| wr_en | input | 1 | Shared write enable |
| rd_en | input | 1 | Shared read enable |
| out_en | input | 1 | Shared output-bus enable |
| din | input | WIDTH | Shared input word |
| wx_in | input | 1 | Write token arrival from the previous slice |
| wx_out | output | 1 | Write token pulse to the next slice |
| rx_in | input | 1 | Read token arrival from the previous slice |
| rx_out | output | 1 | Read token pulse to the next slice |
| dout | output | WIDTH | Local output register |
| dout_drive | output | 1 | High when this slice owns the shared output bus |
| empty_n | output | 1 | Local empty flag, active low |
| full_n | output | 1 | Local full flag, active low |

## Verification
The bench builds a two-slice ring with a depth of four. The token handoffs are the main corner cases. A design that took the token one cycle late would drop the word written or read on the handoff edge. A design whose pulse lasted two cycles would pass the token twice. The bench then fills both slices so that the write token comes back to a full lead slice. It offers one more word there, which a design with a broken full guard would accept, and which would then surface later in the read order. It also reads past empty across the ring wrap and checks that only one slice drives the bus at each step, since a design that drove from the old token holder would show stale data.

// File: rtl/cascade_slice_pkg.sv
package cascade_slice_pkg;

   localparam int GRAY_W = 32;

   function automatic logic [GRAY_W-1:0] to_gray(input logic [GRAY_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [GRAY_W-1:0] from_gray(input logic [GRAY_W-1:0] g);
      logic [GRAY_W-1:0] b;
      b[GRAY_W-1] = g[GRAY_W-1];
      for (int i = GRAY_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/slice_sync.sv
module slice_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= '0;
         end else begin
            if (s == 0) stg[s] <= d;
            else        stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/slice_token.sv
module slice_token (
   input  logic clk,
   input  logic rst_n,
   input  logic lead_n,
   input  logic x_in,
   input  logic req,
   input  logic at_last,
   output logic own,
   output logic held,
   output logic fire,
   output logic x_out
);
   logic tok;
   logic pass;

   assign own  = tok | x_in;
   assign fire = req & own;
   assign pass = fire & at_last;
   assign held = tok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok   <= ~lead_n;
         x_out <= 1'b0;
      end else begin
         x_out <= pass;
         if (pass)      tok <= 1'b0;
         else if (x_in) tok <= 1'b1;
      end
   end

   assert_single_pulse_R3_R5: assert property (@(posedge clk) disable iff (!rst_n)
      x_out |=> !x_out);
   assert_release_R3_R5: assert property (@(posedge clk) disable iff (!rst_n)
      x_out |-> !held);
   assert_take_R4_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in && !(req && at_last)) |=> held);
endmodule

// File: rtl/slice_store.sv
module slice_store #(
   parameter int W     = 18,
   parameter int DEPTH = 8,
   parameter int AW    = 3
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/cascade_slice.sv
module cascade_slice
   import cascade_slice_pkg::*;
#(
   parameter int WIDTH       = 18,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             lead_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             out_en,
   input  logic [WIDTH-1:0] din,
   input  logic             wx_in,
   output logic             wx_out,
   input  logic             rx_in,
   output logic             rx_out,
   output logic [WIDTH-1:0] dout,
   output logic             dout_drive,
   output logic             empty_n,
   output logic             full_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cascade_slice: DEPTH must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cascade_slice: SYNC_STAGES must be at least 2");
   end
   if (WIDTH < 1 || PW > GRAY_W) begin : g_bad_width
      $error("cascade_slice: WIDTH or DEPTH out of range");
   end

   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW-1:0] wr_gray, rd_gray;
   logic [PW-1:0] wr_gray_rs, rd_gray_ws;
   logic [PW-1:0] wr_bin_rs, rd_bin_ws;
   logic          full, empty;
   logic          w_own, w_held, w_fire;
   logic          r_own, r_held, r_fire;

   // write domain
   assign rd_bin_ws = PW'(from_gray(GRAY_W'(rd_gray_ws)));
   assign full      = (wr_ptr[AW] != rd_bin_ws[AW]) && (wr_ptr[AW-1:0] == rd_bin_ws[AW-1:0]);
   assign full_n    = ~full;

   slice_token u_wtok (
      .clk(wclk), .rst_n(rst_n), .lead_n(lead_n), .x_in(wx_in),
      .req(wr_en & ~full), .at_last(wr_ptr[AW-1:0] == LAST),
      .own(w_own), .held(w_held), .fire(w_fire), .x_out(wx_out)
   );

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         wr_gray <= '0;
      end else if (w_fire) begin
         wr_ptr  <= wr_ptr + 1'b1;
         wr_gray <= PW'(to_gray(GRAY_W'(wr_ptr + 1'b1)));
      end
   end

   slice_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_rs)
   );

   // read domain
   assign wr_bin_rs = PW'(from_gray(GRAY_W'(wr_gray_rs)));
   assign empty     = (rd_ptr == wr_bin_rs);
   assign empty_n   = ~empty;

   slice_token u_rtok (
      .clk(rclk), .rst_n(rst_n), .lead_n(lead_n), .x_in(rx_in),
      .req(rd_en & ~empty), .at_last(rd_ptr[AW-1:0] == LAST),
      .own(r_own), .held(r_held), .fire(r_fire), .x_out(rx_out)
   );

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         rd_gray <= '0;
      end else if (r_fire) begin
         rd_ptr  <= rd_ptr + 1'b1;
         rd_gray <= PW'(to_gray(GRAY_W'(rd_ptr + 1'b1)));
      end
   end

   slice_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_ws)
   );

   slice_store #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
      .wclk(wclk), .we(w_fire), .waddr(wr_ptr[AW-1:0]), .wdata(din),
      .rclk(rclk), .rst_n(rst_n), .re(r_fire), .raddr(rd_ptr[AW-1:0]),
      .rdata(dout)
   );

   assign dout_drive = out_en & (r_held | rx_out);

   // guards
   assert_nonowner_R2: assert property (@(posedge wclk) disable iff (!rst_n)
      (!w_own) |=> $stable(wr_ptr));
   assert_full_blocks_R9: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n) |=> (wr_ptr == $past(wr_ptr)));
   assert_empty_holds_R7: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n) |=> $stable(dout));
   assert_drive_owner_R8: assert property (@(posedge rclk) disable iff (!rst_n)
      (!r_held && !rx_out) |-> !dout_drive);
   assert_no_overrun_R9: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_ptr - rd_bin_ws) <= PW'(DEPTH));
endmodule

// File: tb/sim_cascade_slice.sv
module sim_cascade_slice;
   localparam int CLK_P = 10;
   localparam int W     = 18;
   localparam int D     = 4;
   localparam logic [W-1:0] WORDS [8] = '{
      18'h00011, 18'h10022, 18'h20033, 18'h30044,
      18'h0A055, 18'h1B066, 18'h2C077, 18'h3D088};
   localparam logic [W-1:0] DROPPED = 18'h3ABCD;
   localparam logic [W-1:0] LATE    = 18'h0F0F0;

   logic clk = 1'b0;
   logic rst_n, wr_en, rd_en, out_en;
   logic [W-1:0] din;
   logic u0_wxo, u0_rxo, u1_wxo, u1_rxo;
   logic [W-1:0] u0_q, u1_q, bus;
   logic u0_drv, u1_drv, u0_en, u0_fn, u1_en, u1_fn;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cascade_slice #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2)) u0 (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .lead_n(1'b0),
      .wr_en(wr_en), .rd_en(rd_en), .out_en(out_en), .din(din),
      .wx_in(u1_wxo), .wx_out(u0_wxo), .rx_in(u1_rxo), .rx_out(u0_rxo),
      .dout(u0_q), .dout_drive(u0_drv), .empty_n(u0_en), .full_n(u0_fn));

   cascade_slice #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2)) u1 (
      .wclk(clk), .rclk(clk), .rst_n(rst_n), .lead_n(1'b1),
      .wr_en(wr_en), .rd_en(rd_en), .out_en(out_en), .din(din),
      .wx_in(u0_wxo), .wx_out(u1_wxo), .rx_in(u0_rxo), .rx_out(u1_rxo),
      .dout(u1_q), .dout_drive(u1_drv), .empty_n(u1_en), .full_n(u1_fn));

   assign bus = u0_drv ? u0_q : (u1_drv ? u1_q : '0);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; out_en = 1'b1; din = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 u0 empty_n", 32'(u0_en), 0);
      check("R1 u0 full_n", 32'(u0_fn), 1);
      check("R1 u1 empty_n", 32'(u1_en), 0);
      check("R1 lead drives", 32'(u0_drv), 1);
      check("R1 other silent", 32'(u1_drv), 0);
      check("R1 bus zero", 32'(bus), 0);
      check("R1 pulses idle", 32'({u0_wxo, u1_wxo, u0_rxo, u1_rxo}), 0);

      // fill the ring, back to back
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         wr_en = 1'b1; din = WORDS[i];
         tick();
         if (i == 3) begin
            check("R3 u0 wx_out on last location", 32'(u0_wxo), 1);
            check("R9 u0 full after DEPTH words", 32'(u0_fn), 0);
         end
         if (i == 4) check("R3 u0 wx_out single cycle", 32'(u0_wxo), 0);
         if (i >= 4 && i <= 6) check("R2 u1 not full early", 32'(u1_fn), 1);
         if (i == 7) begin
            check("R4 u1 full after four handoff writes", 32'(u1_fn), 0);
            check("R3 u1 wx_out back to lead", 32'(u1_wxo), 1);
         end
      end
      // R9: lead owns token again but is full
      @(negedge clk);
      din = DROPPED;
      tick();
      check("R9 no pass while full", 32'(u0_wxo), 0);
      check("R9 u0 still full", 32'(u0_fn), 0);
      @(negedge clk);
      wr_en = 1'b0;
      repeat (4) tick();
      check("R10 u0 not empty", 32'(u0_en), 1);
      check("R10 u1 not empty", 32'(u1_en), 1);

      // drain the ring
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rd_en = 1'b1;
         tick();
         check($sformatf("R11 R7 word %0d", i), 32'(bus), 32'(WORDS[i]));
         check("R8 one driver", 32'(u0_drv) + 32'(u1_drv), 1);
         if (i == 3) check("R5 u0 rx_out on last location", 32'(u0_rxo), 1);
         if (i == 4) begin
            check("R5 u0 rx_out single cycle", 32'(u0_rxo), 0);
            check("R6 u1 read on arrival edge", 32'(u1_drv), 1);
         end
         if (i == 7) check("R5 u1 rx_out", 32'(u1_rxo), 1);
      end
      // reads past empty
      tick();
      check("R7 no read when empty", 32'({u0_rxo, u1_rxo}), 0);
      check("R8 token back at lead", 32'({u0_drv, u1_drv}), 32'b10);
      check("R10 u0 empty", 32'(u0_en), 0);
      tick();
      check("R10 u1 empty", 32'(u1_en), 0);
      check("R9 u0 full released", 32'(u0_fn), 1);
      @(negedge clk);
      rd_en = 1'b0;

      // order after wrap: dropped word must not appear
      wr_en = 1'b1; din = LATE;
      tick();
      @(negedge clk);
      wr_en = 1'b0;
      repeat (4) tick();
      @(negedge clk);
      rd_en = 1'b1;
      tick();
      check("R11 R2 next word after wrap", 32'(bus), 32'(LATE));
      @(negedge clk);
      rd_en = 1'b0; out_en = 1'b0;
      #1;
      check("R8 bus released", 32'({u0_drv, u1_drv}), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule